// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steers a 16-bit CPU's control flow whenever an interrupt is taken or a subroutine return runs. An interrupt is taken only when its request line is high, its enable bit is set, and the core is either at an instruction boundary or halted. The sequencer then saves the flags word and the return address on a stack in memory that grows downward. It loads the program counter with a vector address that is fixed for each interrupt line. Software places a jump instruction in each vector slot; with the default parameters, line 1 lands at 0x0010.

Two return sequences also run here. A plain return takes one word off the stack and jumps to it. An interrupt return takes the return address off first, then the saved flags, and then jumps. The sequencer owns the stack pointer, so the core's own writes to it pass through this block. Each sequence ends with a single-cycle completion pulse. No new request is accepted before that pulse.

Top module: `irq_return_seq`

## Requirements
- R1: After reset the stack pointer equals SP_RESET (0x1000). busy, done, halted, masked, mem_rd, mem_wr, pc_load and flags_load are all low.
- R2: An accepted interrupt performs two word writes. The flags, zero-extended, go to sp-2 first. The return address (pc_in at acceptance) goes to sp-4 second. sp ends 4 lower than it started.
- R3: Line k loads pc with VEC_BASE + k*VEC_STRIDE, which is 0x0000, 0x0010, 0x0020 and 0x0030 by default. When several enabled lines are pending, the lowest index wins.
- R4: A request whose enable bit is 0 is ignored. So is an enabled request while the core is neither halted nor at a boundary.
- R5: From acceptance until an interrupt return completes, no further interrupt is taken.
- R6: A plain return reads the word at sp, raises sp by 2 and loads pc with that word.
- R7: An interrupt return reads the return address at sp, then the flags at sp+2. It raises sp by 4, loads pc with the address and the flags with the low FLAG_W bits, and clears the mask.
- R8: Cycles from the command edge to done are 2 for entry, 2 for a plain return and 4 for an interrupt return. done is a one-cycle pulse that coincides with pc_load.
- R9: While a sequence is running, return commands and stack-pointer writes are ignored. When a return command and an interrupt arrive in the same cycle, the return runs first and the interrupt follows.
- R10: halt_cmd sets halted. A pending request that is disabled leaves the core halted. An enabled request clears halted and starts entry without any boundary strobe.
- R11: sp_wr loads sp from sp_wdata when the sequencer is idle.
- R12: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Core is between instructions |
| irq_req | input | NUM_IRQ | Level interrupt requests |
| irq_en | input | NUM_IRQ | Per-line enable |
| ret_cmd | input | 1 | Start a plain return |
| iret_cmd | input | 1 | Start an interrupt return |
| halt_cmd | input | 1 | Enter halt state |
| sp_wr | input | 1 | Write stack pointer |
| sp_wdata | input | ADDR_W | New stack pointer value |
| pc_in | input | ADDR_W | Return address to save |
| flags_in | input | FLAG_W | Flags to save |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_rd |
| pc_load | output | 1 | Load program counter |
| pc_value | output | ADDR_W | New program counter |
| flags_load | output | 1 | Restore flags |
| flags_value | output | FLAG_W | Restored flags |
| sp | output | ADDR_W | Current stack pointer |
| halted | output | 1 | Core halted |
| masked | output | 1 | Interrupts blocked (handler active) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished this cycle |

## Verification
The hardest situation to reach is a collision. One case is a return command and an interrupt arriving in the same cycle. The other is commands and stack-pointer writes landing in the middle of an entry sequence. For both, the stimulus holds the request and boundary lines across the whole return. It then drives the competing inputs exactly in the cycle the first push is on the bus. The scoreboard then sees the bus order directly and can detect any operation that slipped in. Plain returns are set up by preloading the bench memory and pointing sp at it, so a return can be tested without any interrupt before it.

// File: rtl/irs_pkg.sv
package irs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_F,
      ST_PUSH_PC,
      ST_POP_PC,
      ST_POP_PC_D,
      ST_POP_F,
      ST_POP_F_D
   } irs_state_e;

   typedef enum logic [1:0] {
      SP_HOLD,
      SP_PUSH,
      SP_POP,
      SP_SET
   } sp_op_e;

endpackage

// File: rtl/irs_irq_pick.sv
module irs_irq_pick #(
   parameter int NUM_IRQ    = 4,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 0,
   parameter int VEC_STRIDE = 16,
   parameter bit LOW_FIRST  = 1'b1
) (
   input  logic [NUM_IRQ-1:0] req_i,
   input  logic [NUM_IRQ-1:0] en_i,
   output logic               hit_o,
   output logic [ADDR_W-1:0]  vec_o
);
   localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

   logic [NUM_IRQ-1:0] live;
   logic [IDX_W-1:0]   sel;

   assign live  = req_i & en_i;
   assign hit_o = |live;

   generate
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            sel = '0;
            for (int i = NUM_IRQ - 1; i >= 0; i--) begin
               if (live[i]) sel = IDX_W'(i);
            end
         end
      end else begin : g_high_first
         always_comb begin
            sel = '0;
            for (int i = 0; i < NUM_IRQ; i++) begin
               if (live[i]) sel = IDX_W'(i);
            end
         end
      end
   endgenerate

   assign vec_o = ADDR_W'(VEC_BASE) + ADDR_W'(sel) * ADDR_W'(VEC_STRIDE);

endmodule

// File: rtl/irs_stack_ptr.sv
module irs_stack_ptr
   import irs_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int STEP     = 2,
   parameter int SP_RESET = 'h1000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  sp_op_e            op_i,
   input  logic [ADDR_W-1:0] set_val_i,
   output logic [ADDR_W-1:0] sp_o
);
   localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(STEP);
   localparam logic [ADDR_W-1:0] RESET_V = ADDR_W'(SP_RESET);

   logic [ADDR_W-1:0] sp_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sp_q <= RESET_V;
      end else begin
         unique case (op_i)
            SP_PUSH: sp_q <= sp_q - STEP_V;
            SP_POP:  sp_q <= sp_q + STEP_V;
            SP_SET:  sp_q <= set_val_i;
            default: sp_q <= sp_q;
         endcase
      end
   end

   assign sp_o = sp_q;

   AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == SP_PUSH |=> sp_o == $past(sp_o) - STEP_V); // R2
   AST_POP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == SP_POP |=> sp_o == $past(sp_o) + STEP_V); // R6
   AST_SP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      op_i == SP_SET |=> sp_o == $past(set_val_i)); // R11

endmodule

// File: rtl/irs_ctrl.sv
module irs_ctrl
   import irs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int FLAG_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              at_boundary_i,
   input  logic              irq_hit_i,
   input  logic [ADDR_W-1:0] irq_vec_i,
   input  logic              ret_i,
   input  logic              iret_i,
   input  logic              halt_i,
   input  logic              sp_wr_i,
   input  logic [ADDR_W-1:0] sp_wdata_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [FLAG_W-1:0] flags_i,
   input  logic [ADDR_W-1:0] sp_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output sp_op_e            sp_op_o,
   output logic [ADDR_W-1:0] sp_set_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic              pc_load_o,
   output logic [ADDR_W-1:0] pc_value_o,
   output logic              flags_load_o,
   output logic [FLAG_W-1:0] flags_value_o,
   output logic              halted_o,
   output logic              masked_o,
   output logic              busy_o,
   output logic              done_o
);
   irs_state_e        st_q, st_d;
   logic [ADDR_W-1:0] ret_q;
   logic [ADDR_W-1:0] vec_q;
   logic [FLAG_W-1:0] flags_q;
   logic [DATA_W-1:0] flags_word;
   logic              iret_q;
   logic              halted_q;
   logic              masked_q;
   logic              take_irq;
   logic              take_ret;
   logic              take_iret;

   generate
      if (FLAG_W < DATA_W) begin : g_flags_pad
         assign flags_word = {{(DATA_W - FLAG_W){1'b0}}, flags_q};
      end else begin : g_flags_full
         assign flags_word = flags_q;
      end
   endgenerate

   always_comb begin
      st_d          = st_q;
      sp_op_o       = SP_HOLD;
      take_irq      = 1'b0;
      take_ret      = 1'b0;
      take_iret     = 1'b0;
      mem_rd_o      = 1'b0;
      mem_wr_o      = 1'b0;
      mem_addr_o    = sp_i;
      mem_wdata_o   = '0;
      pc_load_o     = 1'b0;
      pc_value_o    = '0;
      flags_load_o  = 1'b0;
      flags_value_o = '0;
      done_o        = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (ret_i) begin
               take_ret = 1'b1;
               st_d     = ST_POP_PC;
            end else if (iret_i) begin
               take_iret = 1'b1;
               st_d      = ST_POP_PC;
            end else if (irq_hit_i && !masked_q && (at_boundary_i || halted_q)) begin
               take_irq = 1'b1;
               sp_op_o  = SP_PUSH;
               st_d     = ST_PUSH_F;
            end else if (sp_wr_i) begin
               sp_op_o = SP_SET;
            end
         end
         ST_PUSH_F: begin
            mem_wr_o    = 1'b1;
            mem_wdata_o = flags_word;
            sp_op_o     = SP_PUSH;
            st_d        = ST_PUSH_PC;
         end
         ST_PUSH_PC: begin
            mem_wr_o    = 1'b1;
            mem_wdata_o = DATA_W'(ret_q);
            pc_load_o   = 1'b1;
            pc_value_o  = vec_q;
            done_o      = 1'b1;
            st_d        = ST_IDLE;
         end
         ST_POP_PC: begin
            mem_rd_o = 1'b1;
            sp_op_o  = SP_POP;
            st_d     = ST_POP_PC_D;
         end
         ST_POP_PC_D: begin
            if (iret_q) begin
               st_d = ST_POP_F;
            end else begin
               pc_load_o  = 1'b1;
               pc_value_o = mem_rdata_i[ADDR_W-1:0];
               done_o     = 1'b1;
               st_d       = ST_IDLE;
            end
         end
         ST_POP_F: begin
            mem_rd_o = 1'b1;
            sp_op_o  = SP_POP;
            st_d     = ST_POP_F_D;
         end
         ST_POP_F_D: begin
            flags_load_o  = 1'b1;
            flags_value_o = mem_rdata_i[FLAG_W-1:0];
            pc_load_o     = 1'b1;
            pc_value_o    = ret_q;
            done_o        = 1'b1;
            st_d          = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         ret_q    <= '0;
         vec_q    <= '0;
         flags_q  <= '0;
         iret_q   <= 1'b0;
         halted_q <= 1'b0;
         masked_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (take_irq) begin
            ret_q    <= pc_i;
            vec_q    <= irq_vec_i;
            flags_q  <= flags_i;
            masked_q <= 1'b1;
            halted_q <= 1'b0;
         end else if (st_q == ST_IDLE && halt_i) begin
            halted_q <= 1'b1;
         end
         if (take_ret)  iret_q <= 1'b0;
         if (take_iret) iret_q <= 1'b1;
         if (st_q == ST_POP_PC_D) ret_q <= mem_rdata_i[ADDR_W-1:0];
         if (st_q == ST_POP_F_D)  masked_q <= 1'b0;
      end
   end

   assign sp_set_o = sp_wdata_i;
   assign halted_o = halted_q;
   assign masked_o = masked_q;
   assign busy_o   = (st_q != ST_IDLE);

   AST_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(mem_rd_o && mem_wr_o)); // R12
   AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R8
   AST_NO_NEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (masked_o && st_q == ST_IDLE) |=> st_q != ST_PUSH_F); // R5
   AST_HALT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(halted_o) |-> st_q == ST_PUSH_F); // R10
   AST_IRET_UNMASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_load_o |=> !masked_o); // R7

endmodule

// File: rtl/irq_return_seq.sv
module irq_return_seq
   import irs_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter int FLAG_W     = 4,
   parameter int NUM_IRQ    = 4,
   parameter int VEC_BASE   = 0,
   parameter int VEC_STRIDE = 16,
   parameter int SP_RESET   = 'h1000,
   parameter bit LOW_FIRST  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               at_boundary,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               ret_cmd,
   input  logic               iret_cmd,
   input  logic               halt_cmd,
   input  logic               sp_wr,
   input  logic [ADDR_W-1:0]  sp_wdata,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic [FLAG_W-1:0]  flags_in,
   output logic               mem_rd,
   output logic               mem_wr,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               pc_load,
   output logic [ADDR_W-1:0]  pc_value,
   output logic               flags_load,
   output logic [FLAG_W-1:0]  flags_value,
   output logic [ADDR_W-1:0]  sp,
   output logic               halted,
   output logic               masked,
   output logic               busy,
   output logic               done
);
   localparam int STEP = DATA_W / 8;

   initial begin
      assert (DATA_W >= 8 && DATA_W % 8 == 0) else $fatal(1, "DATA_W must be whole bytes");
      assert (ADDR_W == DATA_W) else $fatal(1, "return address must fill one stack word");
      assert (FLAG_W >= 1 && FLAG_W <= DATA_W) else $fatal(1, "FLAG_W out of range");
      assert (NUM_IRQ >= 1) else $fatal(1, "NUM_IRQ must be at least 1");
      assert (VEC_STRIDE >= 2 * STEP) else $fatal(1, "vector slot too small for a jump");
   end

   logic              irq_hit;
   logic [ADDR_W-1:0] irq_vec;
   sp_op_e            sp_op;
   logic [ADDR_W-1:0] sp_set;

   irs_irq_pick #(
      .NUM_IRQ    (NUM_IRQ),
      .ADDR_W     (ADDR_W),
      .VEC_BASE   (VEC_BASE),
      .VEC_STRIDE (VEC_STRIDE),
      .LOW_FIRST  (LOW_FIRST)
   ) i_pick (
      .req_i (irq_req),
      .en_i  (irq_en),
      .hit_o (irq_hit),
      .vec_o (irq_vec)
   );

   irs_stack_ptr #(
      .ADDR_W   (ADDR_W),
      .STEP     (STEP),
      .SP_RESET (SP_RESET)
   ) i_sp (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .op_i      (sp_op),
      .set_val_i (sp_set),
      .sp_o      (sp)
   );

   irs_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .FLAG_W (FLAG_W)
   ) i_ctrl (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .at_boundary_i (at_boundary),
      .irq_hit_i     (irq_hit),
      .irq_vec_i     (irq_vec),
      .ret_i         (ret_cmd),
      .iret_i        (iret_cmd),
      .halt_i        (halt_cmd),
      .sp_wr_i       (sp_wr),
      .sp_wdata_i    (sp_wdata),
      .pc_i          (pc_in),
      .flags_i       (flags_in),
      .sp_i          (sp),
      .mem_rdata_i   (mem_rdata),
      .sp_op_o       (sp_op),
      .sp_set_o      (sp_set),
      .mem_rd_o      (mem_rd),
      .mem_wr_o      (mem_wr),
      .mem_addr_o    (mem_addr),
      .mem_wdata_o   (mem_wdata),
      .pc_load_o     (pc_load),
      .pc_value_o    (pc_value),
      .flags_load_o  (flags_load),
      .flags_value_o (flags_value),
      .halted_o      (halted),
      .masked_o      (masked),
      .busy_o        (busy),
      .done_o        (done)
   );

endmodule

// File: tb/test_irq_return_seq.sv
module test_irq_return_seq;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        at_boundary, ret_cmd, iret_cmd, halt_cmd, sp_wr;
   logic [3:0]  irq_req, irq_en, flags_in;
   logic [15:0] sp_wdata, pc_in;
   logic        mem_rd, mem_wr, pc_load, flags_load, halted, masked, busy, done;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, pc_value, sp;
   logic [3:0]  flags_value;

   logic [15:0] mem [0:255];

   typedef struct {
      int          kind;
      logic [15:0] addr;
      logic [15:0] data;
      string       tag;
   } ev_t;
   ev_t exp_q[$];

   int n_chk  = 0;
   int n_fail = 0;
   bit fin    = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_return_seq i_irq_return_seq (
      .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .irq_req(irq_req), .irq_en(irq_en),
      .ret_cmd(ret_cmd), .iret_cmd(iret_cmd), .halt_cmd(halt_cmd), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
      .pc_in(pc_in), .flags_in(flags_in), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_load(pc_load), .pc_value(pc_value),
      .flags_load(flags_load), .flags_value(flags_value), .sp(sp), .halted(halted), .masked(masked),
      .busy(busy), .done(done)
   );

   always @(posedge clk) begin
      if (mem_wr) mem[mem_addr[8:1]] <= mem_wdata;
      if (mem_rd) mem_rdata <= mem[mem_addr[8:1]];
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic expect_ev(int kind, logic [15:0] addr, logic [15:0] data, string tag);
      ev_t e;
      e.kind = kind; e.addr = addr; e.data = data; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic observe(int kind, logic [15:0] addr, logic [15:0] data);
      ev_t e;
      if (exp_q.size() == 0) begin
         chk("R9 unexpected bus event", {kind[15:0], addr}, 32'hFFFF_FFFF);
      end else begin
         e = exp_q.pop_front();
         chk({e.tag, " kind"}, kind, e.kind);
         chk({e.tag, " addr"}, {16'h0, addr}, {16'h0, e.addr});
         if (kind == 0) chk({e.tag, " data"}, {16'h0, data}, {16'h0, e.data});
      end
   endtask

   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (mem_wr)     observe(0, mem_addr, mem_wdata);
         if (mem_rd)     observe(1, mem_addr, 16'h0);
         if (pc_load)    observe(2, pc_value, 16'h0);
         if (flags_load) observe(3, {12'h0, flags_value}, 16'h0);
         if (pc_load && !done) chk("R8 done with pc_load", {31'h0, done}, 32'h1);
      end
   end

   task automatic clear_cmds();
      at_boundary = 1'b0; ret_cmd = 1'b0; iret_cmd = 1'b0; halt_cmd = 1'b0; sp_wr = 1'b0;
   endtask

   task automatic run_seq(int n, string tag);
      @(negedge clk);
      clear_cmds();
      for (int k = 1; k < n; k++) begin
         chk({tag, " done early"}, {31'h0, done}, 32'h0);
         @(negedge clk);
      end
      chk({tag, " done on time"}, {31'h0, done}, 32'h1);
   endtask

   task automatic idle_cycles(int n, string tag);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk({tag, " stays idle"}, {31'h0, busy}, 32'h0);
      end
   endtask

   task automatic set_sp(logic [15:0] v);
      sp_wr = 1'b1; sp_wdata = v;
      @(negedge clk);
      sp_wr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!fin) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; clear_cmds();
      irq_req = '0; irq_en = '0; flags_in = '0; sp_wdata = '0; pc_in = '0;
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sp", {16'h0, sp}, 32'h1000);
      chk("R1 busy", {31'h0, busy}, 0);
      chk("R1 halted", {31'h0, halted}, 0);
      chk("R1 masked", {31'h0, masked}, 0);
      chk("R1 done", {31'h0, done}, 0);
      chk("R1 bus", {29'h0, mem_rd, mem_wr, pc_load}, 0);

      // R11 stack pointer write
      set_sp(16'h0100);
      chk("R11 sp write", {16'h0, sp}, 32'h0100);

      // R2 R3 R8 entry on line 1
      expect_ev(0, 16'h00FE, 16'h000A, "R2 flags push");
      expect_ev(0, 16'h00FC, 16'h0420, "R2 ret push");
      expect_ev(2, 16'h0010, 16'h0, "R3 vector line1");
      irq_en = 4'hF; irq_req = 4'b0010; pc_in = 16'h0420; flags_in = 4'hA; at_boundary = 1'b1;
      run_seq(2, "R8 entry");
      @(negedge clk);
      chk("R2 sp after entry", {16'h0, sp}, 32'h00FC);
      chk("R5 masked set", {31'h0, masked}, 1);

      // R5 no nesting while masked
      irq_req = 4'b0001; at_boundary = 1'b1;
      idle_cycles(3, "R5");
      at_boundary = 1'b0; irq_req = '0;
      chk("R5 sp unchanged", {16'h0, sp}, 32'h00FC);

      // R6 plain return from preloaded stack
      mem[8'h7D] = 16'h0555;
      set_sp(16'h00FA);
      expect_ev(1, 16'h00FA, 16'h0, "R6 pop read");
      expect_ev(2, 16'h0555, 16'h0, "R6 pc load");
      ret_cmd = 1'b1;
      run_seq(2, "R8 ret");
      @(negedge clk);
      chk("R6 sp after ret", {16'h0, sp}, 32'h00FC);

      // R7 interrupt return
      expect_ev(1, 16'h00FC, 16'h0, "R7 pop ret");
      expect_ev(1, 16'h00FE, 16'h0, "R7 pop flags");
      expect_ev(2, 16'h0420, 16'h0, "R7 pc");
      expect_ev(3, 16'h000A, 16'h0, "R7 flags");
      iret_cmd = 1'b1;
      run_seq(4, "R8 iret");
      @(negedge clk);
      chk("R7 sp after iret", {16'h0, sp}, 32'h0100);
      chk("R7 unmasked", {31'h0, masked}, 0);

      // R4 disabled line, and enabled line off boundary
      irq_req = 4'b0100; irq_en = 4'b1011; at_boundary = 1'b1;
      idle_cycles(3, "R4 disabled");
      irq_en = 4'hF; at_boundary = 1'b0;
      idle_cycles(3, "R4 no boundary");
      irq_req = '0;

      // R3 priority: lowest index wins
      expect_ev(0, 16'h00FE, 16'h0003, "R3 flags push");
      expect_ev(0, 16'h00FC, 16'h0600, "R3 ret push");
      expect_ev(2, 16'h0000, 16'h0, "R3 vector line0");
      irq_req = 4'b0101; flags_in = 4'h3; pc_in = 16'h0600; at_boundary = 1'b1;
      run_seq(2, "R3 entry");
      irq_req = '0;
      expect_ev(1, 16'h00FC, 16'h0, "R7 pop ret");
      expect_ev(1, 16'h00FE, 16'h0, "R7 pop flags");
      expect_ev(2, 16'h0600, 16'h0, "R7 pc");
      expect_ev(3, 16'h0003, 16'h0, "R7 flags");
      @(negedge clk);
      iret_cmd = 1'b1;
      run_seq(4, "R7 iret");

      // R9 commands during entry are ignored
      expect_ev(0, 16'h00FE, 16'h0005, "R9 flags push");
      expect_ev(0, 16'h00FC, 16'h0700, "R9 ret push");
      expect_ev(2, 16'h0020, 16'h0, "R3 vector line2");
      @(negedge clk);
      irq_req = 4'b0100; flags_in = 4'h5; pc_in = 16'h0700; at_boundary = 1'b1;
      @(negedge clk);
      at_boundary = 1'b0;
      ret_cmd = 1'b1; iret_cmd = 1'b1; sp_wr = 1'b1; sp_wdata = 16'h0200;
      @(negedge clk);
      clear_cmds();
      chk("R9 done mid collision", {31'h0, done}, 1);
      irq_req = '0;
      @(negedge clk);
      chk("R11 sp write ignored when busy", {16'h0, sp}, 32'h00FC);
      chk("R9 back to idle", {31'h0, busy}, 0);
      expect_ev(1, 16'h00FC, 16'h0, "R7 pop ret");
      expect_ev(1, 16'h00FE, 16'h0, "R7 pop flags");
      expect_ev(2, 16'h0700, 16'h0, "R7 pc");
      expect_ev(3, 16'h0005, 16'h0, "R7 flags");
      iret_cmd = 1'b1;
      run_seq(4, "R7 iret");

      // R9 return and interrupt in the same cycle: return first
      mem[8'h80] = 16'h0888;
      @(negedge clk);
      expect_ev(1, 16'h0100, 16'h0, "R9 ret read");
      expect_ev(2, 16'h0888, 16'h0, "R9 ret pc");
      expect_ev(0, 16'h0100, 16'h0006, "R9 later flags push");
      expect_ev(0, 16'h00FE, 16'h0900, "R9 later ret push");
      expect_ev(2, 16'h0010, 16'h0, "R9 later vector");
      ret_cmd = 1'b1; irq_req = 4'b0010; at_boundary = 1'b1; flags_in = 4'h6; pc_in = 16'h0900;
      @(negedge clk);
      ret_cmd = 1'b0;
      @(negedge clk);
      chk("R9 ret done first", {31'h0, done}, 1);
      @(negedge clk);
      chk("R9 idle between", {31'h0, busy}, 0);
      @(negedge clk);
      at_boundary = 1'b0;
      chk("R9 irq follows", {31'h0, busy}, 1);
      @(negedge clk);
      chk("R9 irq done", {31'h0, done}, 1);
      irq_req = '0;
      @(negedge clk);
      chk("R9 sp after pair", {16'h0, sp}, 32'h00FE);
      expect_ev(1, 16'h00FE, 16'h0, "R7 pop ret");
      expect_ev(1, 16'h0100, 16'h0, "R7 pop flags");
      expect_ev(2, 16'h0900, 16'h0, "R7 pc");
      expect_ev(3, 16'h0006, 16'h0, "R7 flags");
      iret_cmd = 1'b1;
      run_seq(4, "R7 iret");

      // R10 halt, disabled request, then wake on enabled one
      @(negedge clk);
      halt_cmd = 1'b1;
      @(negedge clk);
      halt_cmd = 1'b0;
      chk("R10 halted set", {31'h0, halted}, 1);
      irq_req = 4'b1000; irq_en = 4'b0111; flags_in = 4'h7; pc_in = 16'h0A00;
      idle_cycles(3, "R10 disabled while halted");
      chk("R10 still halted", {31'h0, halted}, 1);
      expect_ev(0, 16'h0100, 16'h0007, "R10 flags push");
      expect_ev(0, 16'h00FE, 16'h0A00, "R10 ret push");
      expect_ev(2, 16'h0030, 16'h0, "R3 vector line3");
      irq_en = 4'hF;
      run_seq(2, "R10 wake entry");
      chk("R10 halt cleared", {31'h0, halted}, 0);
      irq_req = '0;

      repeat (3) @(negedge clk);
      chk("R2 scoreboard drained", exp_q.size(), 0);
      fin = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule